// File: doc/BRIEF.md
# Oversampled Serial Receiver with Address Marking

This block is the receive half of an asynchronous serial port. A free-running oversampling strobe arrives at sixteen times the bit rate. The block watches the serial line on each strobe and confirms a start bit at its middle. It then samples 5 to 9 data bits, an optional parity bit and the stop bit, each at the centre of its bit period. Each finished character goes into a small queue together with three flags: parity error, framing error and address marker. The queue can be set to one entry or to four entries, and it never overwrites stored data.

On a multidrop network, nine-bit characters can carry an address marker in their top bit. With address marking enabled, that bit is copied into the entry's marker flag so that software can pick out address bytes. The block also spots a break, which is a line held low through a whole character. A break produces a one-clock event and creates no entry.

The read side is valid/ready. `rd_valid` is high whenever the queue holds a character, and the head entry stays on the read pins until a cycle with both `rd_valid` and `rd_ready` high removes it. `rd_ready` is ignored while the queue is empty. The receiver itself cannot be stalled. A character that arrives at a full queue is dropped and sets a sticky overrun flag.

Top module: `srx_mdrop_rx`

## Requirements
- R1: A low line seen on a strobe while idle starts a candidate start bit. The line is sampled again 8 strobes later. If it is high there, the candidate is discarded and no character is produced.
- R2: After a confirmed start bit, data bits are sampled every 16 strobes, LSB first. The count of data bits is `cfg_bits` clamped to the range 5..9. `rd_data` is right-aligned and its unused upper bits read 0.
- R3: `cfg_par` selects the parity bit that follows the data: 0 = none, 1 = even, 2 = odd, 3 = always 1, 4 = always 0. Any other code is treated as none. `rd_perr` is set when the received parity bit disagrees with the selected rule.
- R4: A stop bit sampled low sets `rd_ferr`, and the character is still stored, unless R5 applies.
- R5: When the data bits, the parity bit (if any) and the stop bit are all sampled low, `brk_pulse` is high for exactly one clock. No entry is stored, and the receiver waits for the line to go high before it looks for a new start bit.
- R6: `rd_addr` is 1 only when `cfg_addr_en` is 1, the data bit count is 9 and data bit 8 is 1. Otherwise it is 0.
- R7: With `cfg_deep` = 1 the queue holds 4 entries, and with `cfg_deep` = 0 it holds 1. Entries are read in arrival order, and `rd_level` gives the current fill.
- R8: A character that arrives while the queue is full (and is not popped in the same cycle) is dropped, and `ovr_flag` is set. The flag stays set until the next pop.
- R9: `rd_valid` equals a non-empty queue. While `rd_valid` is high and `rd_ready` is low, the head entry stays unchanged.
- R10: `irq` is high when any of these holds: `rd_level` reaches the threshold (with `cfg_deep` = 1 the threshold is `cfg_trig`+1 entries, i.e. 1/4, 1/2, 3/4 or full; with `cfg_deep` = 0 it is 1), the head entry carries a parity error, framing error or address marker, `ovr_flag` is high, or `brk_pulse` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| rx_in | input | 1 | Serial line, asynchronous, idle high |
| os_tick | input | 1 | Oversampling strobe, 16 per bit, one clock wide |
| cfg_bits | input | 4 | Data bits per character (5..9, clamped) |
| cfg_par | input | 3 | Parity rule code |
| cfg_deep | input | 1 | 1 = four-entry queue, 0 = one entry |
| cfg_trig | input | 2 | Fill threshold select for the four-entry queue |
| cfg_addr_en | input | 1 | Enable address marker flagging |
| rd_valid | output | 1 | Head entry available |
| rd_ready | input | 1 | Consumer accepts the head entry |
| rd_data | output | 9 | Head character data |
| rd_perr | output | 1 | Head parity error flag |
| rd_ferr | output | 1 | Head framing error flag |
| rd_addr | output | 1 | Head address marker flag |
| rd_level | output | 3 | Number of stored entries |
| ovr_flag | output | 1 | Sticky overrun flag |
| brk_pulse | output | 1 | One-clock break event |
| irq | output | 1 | Interrupt request |

## Verification
The line passes through a two-stage synchronizer. The stop bit is judged on the strobe at its centre, the deframer registers the outcome one clock later, and the queue commits it on the next clock. A character is therefore on the read pins about four clocks after the mid-stop strobe, and `irq` follows in the same cycle as the fill level. The bench holds the line idle for one full bit period (64 clocks) after every stop bit before it samples any read pin. It samples on falling edges, well after the character is due. `brk_pulse` lasts only a single clock, so the bench counts it on every rising edge and compares the count once the line has returned high.

// File: rtl/srx_pkg.sv
package srx_pkg;
  localparam int MAX_BITS = 9;
  localparam int MIN_BITS = 5;

  localparam logic [2:0] PAR_NONE  = 3'd0;
  localparam logic [2:0] PAR_EVEN  = 3'd1;
  localparam logic [2:0] PAR_ODD   = 3'd2;
  localparam logic [2:0] PAR_MARK  = 3'd3;
  localparam logic [2:0] PAR_SPACE = 3'd4;

  typedef struct packed {
    logic [MAX_BITS-1:0] data;
    logic                perr;
    logic                ferr;
    logic                addr;
  } srx_char_t;

  function automatic logic [3:0] clamp_bits(input logic [3:0] req);
    if (req < 4'(MIN_BITS))      return 4'(MIN_BITS);
    else if (req > 4'(MAX_BITS)) return 4'(MAX_BITS);
    else                         return req;
  endfunction

  function automatic logic par_used(input logic [2:0] mode);
    return (mode == PAR_EVEN) || (mode == PAR_ODD) ||
           (mode == PAR_MARK) || (mode == PAR_SPACE);
  endfunction
endpackage

// File: rtl/srx_sync.sv
module srx_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] chain;

  generate
    for (genvar s = 0; s < STAGES; s++) begin : g_stage
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain[s] <= 1'b1;
        else if (s == 0) chain[s] <= d;
        else chain[s] <= chain[(s == 0) ? 0 : s-1];
      end
    end
  endgenerate

  assign q = chain[STAGES-1];
endmodule

// File: rtl/srx_deframer.sv
module srx_deframer
  import srx_pkg::*;
#(
  parameter int OSR = 16
) (
  input  logic      clk,
  input  logic      rst_n,
  input  logic      rx,
  input  logic      tick,
  input  logic [3:0] cfg_bits,
  input  logic [2:0] cfg_par,
  input  logic      cfg_addr_en,
  output logic      chr_v,
  output srx_char_t chr,
  output logic      brk
);
  localparam int CW   = $clog2(OSR);
  localparam int BW   = $clog2(MAX_BITS);
  localparam int MID  = OSR/2 - 1;
  localparam int LAST = OSR - 1;

  typedef enum logic [2:0] {S_IDLE, S_START, S_DATA, S_PAR, S_STOP, S_BRKW} st_e;

  st_e                 st;
  logic [CW-1:0]       cnt;
  logic [BW-1:0]       bidx;
  logic [MAX_BITS-1:0] shdat;
  logic                pbit;
  logic                all_low;
  logic [3:0]          nb;
  logic                perr_w;
  logic                bit_end;

  assign nb      = clamp_bits(cfg_bits);
  assign bit_end = (cnt == CW'(LAST));

  always_comb begin
    case (cfg_par)
      PAR_EVEN:  perr_w = (^shdat) ^ pbit;
      PAR_ODD:   perr_w = ~((^shdat) ^ pbit);
      PAR_MARK:  perr_w = ~pbit;
      PAR_SPACE: perr_w = pbit;
      default:   perr_w = 1'b0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st      <= S_IDLE;
      cnt     <= '0;
      bidx    <= '0;
      shdat   <= '0;
      pbit    <= 1'b0;
      all_low <= 1'b1;
      chr_v   <= 1'b0;
      brk     <= 1'b0;
      chr     <= '0;
    end else begin
      chr_v <= 1'b0;
      brk   <= 1'b0;
      if (tick) begin
        case (st)
          S_IDLE: begin
            if (!rx) begin
              st  <= S_START;
              cnt <= '0;
            end
          end
          S_START: begin
            if (cnt == CW'(MID)) begin
              cnt <= '0;
              if (!rx) begin
                st      <= S_DATA;
                bidx    <= '0;
                shdat   <= '0;
                pbit    <= 1'b0;
                all_low <= 1'b1;
              end else begin
                st <= S_IDLE;
              end
            end else begin
              cnt <= cnt + 1'b1;
            end
          end
          S_DATA: begin
            if (bit_end) begin
              cnt         <= '0;
              shdat[bidx] <= rx;
              if (rx) all_low <= 1'b0;
              bidx <= bidx + 1'b1;
              if (4'(bidx) == nb - 4'd1)
                st <= par_used(cfg_par) ? S_PAR : S_STOP;
            end else begin
              cnt <= cnt + 1'b1;
            end
          end
          S_PAR: begin
            if (bit_end) begin
              cnt  <= '0;
              pbit <= rx;
              st   <= S_STOP;
            end else begin
              cnt <= cnt + 1'b1;
            end
          end
          S_STOP: begin
            if (bit_end) begin
              cnt <= '0;
              if (!rx && all_low && (!par_used(cfg_par) || !pbit)) begin
                brk <= 1'b1;
                st  <= S_BRKW;
              end else begin
                chr_v     <= 1'b1;
                chr.data  <= shdat;
                chr.perr  <= perr_w;
                chr.ferr  <= ~rx;
                chr.addr  <= cfg_addr_en && (nb == 4'(MAX_BITS)) && shdat[MAX_BITS-1];
                st        <= S_IDLE;
              end
            end else begin
              cnt <= cnt + 1'b1;
            end
          end
          S_BRKW: begin
            if (rx) st <= S_IDLE;
          end
          default: st <= S_IDLE;
        endcase
      end
    end
  end
endmodule

// File: rtl/srx_fifo.sv
module srx_fifo
  import srx_pkg::*;
#(
  parameter int DEPTH = 4,
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int LW = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [LW-1:0] cap,
  input  logic          push,
  input  srx_char_t     wdat,
  input  logic          pop,
  output srx_char_t     head,
  output logic [LW-1:0] level,
  output logic          full
);
  srx_char_t     mem [DEPTH];
  logic [AW-1:0] wptr, rptr;
  logic          do_push, do_pop;

  assign full    = (level >= cap);
  assign do_pop  = pop && (level != '0);
  assign do_push = push && (!full || do_pop);
  assign head    = mem[rptr];

  function automatic logic [AW-1:0] nxt(input logic [AW-1:0] p);
    return (p == AW'(DEPTH-1)) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wptr  <= '0;
      rptr  <= '0;
      level <= '0;
      for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
    end else begin
      if (do_push) begin
        mem[wptr] <= wdat;
        wptr      <= nxt(wptr);
      end
      if (do_pop) rptr <= nxt(rptr);
      if (do_push && !do_pop)      level <= level + 1'b1;
      else if (do_pop && !do_push) level <= level - 1'b1;
    end
  end
endmodule

// File: rtl/srx_mdrop_rx.sv
module srx_mdrop_rx
  import srx_pkg::*;
#(
  parameter int OSR         = 16,
  parameter int DEPTH       = 4,
  parameter int SYNC_STAGES = 2,
  localparam int LW = $clog2(DEPTH + 1)
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                rx_in,
  input  logic                os_tick,
  input  logic [3:0]          cfg_bits,
  input  logic [2:0]          cfg_par,
  input  logic                cfg_deep,
  input  logic [1:0]          cfg_trig,
  input  logic                cfg_addr_en,
  output logic                rd_valid,
  input  logic                rd_ready,
  output logic [MAX_BITS-1:0] rd_data,
  output logic                rd_perr,
  output logic                rd_ferr,
  output logic                rd_addr,
  output logic [LW-1:0]       rd_level,
  output logic                ovr_flag,
  output logic                brk_pulse,
  output logic                irq
);
  logic      rx_s;
  logic      chr_v;
  srx_char_t chr, head;
  logic      q_full;
  logic      pop;
  logic [LW-1:0] cap, thr;

  srx_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .d(rx_in), .q(rx_s)
  );

  srx_deframer #(.OSR(OSR)) u_dfr (
    .clk(clk), .rst_n(rst_n), .rx(rx_s), .tick(os_tick),
    .cfg_bits(cfg_bits), .cfg_par(cfg_par), .cfg_addr_en(cfg_addr_en),
    .chr_v(chr_v), .chr(chr), .brk(brk_pulse)
  );

  assign cap = cfg_deep ? LW'(DEPTH) : LW'(1);

  srx_fifo #(.DEPTH(DEPTH)) u_q (
    .clk(clk), .rst_n(rst_n), .cap(cap), .push(chr_v), .wdat(chr),
    .pop(pop), .head(head), .level(rd_level), .full(q_full)
  );

  assign rd_valid = (rd_level != '0);
  assign pop      = rd_valid && rd_ready;
  assign rd_data  = head.data;
  assign rd_perr  = head.perr;
  assign rd_ferr  = head.ferr;
  assign rd_addr  = head.addr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                        ovr_flag <= 1'b0;
    else if (chr_v && q_full && !pop)  ovr_flag <= 1'b1;
    else if (pop)                      ovr_flag <= 1'b0;
  end

  always_comb begin
    int t;
    t   = ((int'(cfg_trig) + 1) * DEPTH) / 4;
    if (t < 1) t = 1;
    thr = cfg_deep ? LW'(t) : LW'(1);
  end

  assign irq = (rd_level >= thr) ||
               (rd_valid && (head.perr || head.ferr || head.addr)) ||
               ovr_flag || brk_pulse;
endmodule

// File: rtl/srx_mdrop_rx_chk.sv
module srx_mdrop_rx_chk #(
  parameter int DEPTH = 4,
  localparam int LW = $clog2(DEPTH + 1)
) (
  input logic          clk,
  input logic          rst_n,
  input logic          cfg_deep,
  input logic [1:0]    cfg_trig,
  input logic          rd_valid,
  input logic          rd_ready,
  input logic [8:0]    rd_data,
  input logic          rd_addr,
  input logic [LW-1:0] rd_level,
  input logic          ovr_flag,
  input logic          brk_pulse,
  input logic          irq
);
  int thr_c;
  always_comb begin
    thr_c = cfg_deep ? ((int'(cfg_trig) + 1) * DEPTH) / 4 : 1;
    if (thr_c < 1) thr_c = 1;
  end

  // R7: fill never exceeds the selected capacity
  a_r7_level_cap: assert property (@(posedge clk) disable iff (!rst_n)
    int'(rd_level) <= (cfg_deep ? DEPTH : 1));

  // R9: head entry held while stalled
  a_r9_hold_head: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_valid && !rd_ready) |=> (rd_valid && $stable(rd_data)));

  // R8: overrun flag sticks until a pop
  a_r8_ovr_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (ovr_flag && !(rd_valid && rd_ready)) |=> ovr_flag);

  // R5: break event lasts one clock
  a_r5_brk_single: assert property (@(posedge clk) disable iff (!rst_n)
    brk_pulse |=> !brk_pulse);

  // R6: marker only on a set top data bit
  a_r6_addr_bit: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_valid && rd_addr) |-> rd_data[8]);

  // R10: threshold reached raises the request
  a_r10_irq_thr: assert property (@(posedge clk) disable iff (!rst_n)
    (int'(rd_level) >= thr_c) |-> irq);
endmodule

bind srx_mdrop_rx srx_mdrop_rx_chk #(.DEPTH(DEPTH)) u_chk (
  .clk(clk), .rst_n(rst_n), .cfg_deep(cfg_deep), .cfg_trig(cfg_trig),
  .rd_valid(rd_valid), .rd_ready(rd_ready), .rd_data(rd_data),
  .rd_addr(rd_addr), .rd_level(rd_level), .ovr_flag(ovr_flag),
  .brk_pulse(brk_pulse), .irq(irq)
);

// File: tb/sim_srx_mdrop_rx.sv
`timescale 1ns/1ps
module sim_srx_mdrop_rx;
  localparam int BITCLK = 64;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       rx_in = 1'b1;
  logic       os_tick;
  logic [3:0] cfg_bits = 4'd8;
  logic [2:0] cfg_par = 3'd0;
  logic       cfg_deep = 1'b1;
  logic [1:0] cfg_trig = 2'd3;
  logic       cfg_addr_en = 1'b0;
  logic       rd_valid, rd_ready = 1'b0;
  logic [8:0] rd_data;
  logic       rd_perr, rd_ferr, rd_addr;
  logic [2:0] rd_level;
  logic       ovr_flag, brk_pulse, irq;

  int n_chk = 0, n_bad = 0, brk_cnt = 0;
  logic [1:0] tcnt = 2'd0;
  bit done = 0;

  always #2 clk = ~clk;
  always @(negedge clk) tcnt <= tcnt + 2'd1;
  assign os_tick = (tcnt == 2'd0);
  always @(posedge clk) if (rst_n && brk_pulse) brk_cnt <= brk_cnt + 1;

  srx_mdrop_rx u0 (.*);

  task automatic chk(input string rq, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", rq, act, exp);
    end
  endtask

  function automatic int eff_bits(input int b);
    return (b < 5) ? 5 : (b > 9) ? 9 : b;
  endfunction

  function automatic bit par_of(input logic [8:0] d, input int pm);
    case (pm)
      1: return ^d;
      2: return ~^d;
      3: return 1'b1;
      default: return 1'b0;
    endcase
  endfunction

  task automatic line_bit(input bit v);
    rx_in = v;
    repeat (BITCLK) @(negedge clk);
  endtask

  task automatic send(input logic [8:0] d, input bit flip, input bit bad_stop);
    int nb = eff_bits(int'(cfg_bits));
    logic [8:0] m = d & 9'((1 << nb) - 1);
    line_bit(1'b0);
    for (int i = 0; i < nb; i++) line_bit(m[i]);
    if (cfg_par >= 3'd1 && cfg_par <= 3'd4) line_bit(par_of(m, int'(cfg_par)) ^ flip);
    line_bit(!bad_stop);
    line_bit(1'b1);
  endtask

  task automatic pop_expect(input string rq, input logic [8:0] d, input bit pe,
                            input bit fe, input bit ad);
    chk(rq, {rd_valid, rd_data, rd_perr, rd_ferr, rd_addr}, {1'b1, d, pe, fe, ad});
    rd_ready = 1'b1;
    @(negedge clk);
    rd_ready = 1'b0;
  endtask

  initial begin
    void'($urandom(32'd4242));
    repeat (5) @(negedge clk);
    chk("R9 reset valid", rd_valid, 0);
    chk("R10 reset irq", irq, 0);
    chk("R8 reset ovr", ovr_flag, 0);
    rst_n = 1'b1;
    repeat (8) @(negedge clk);

    // R2 R3 R4 R6: random characters, configs and injected errors
    for (int k = 0; k < 40; k++) begin
      int nb;
      logic [8:0] d, m;
      bit flip, bad, ad;
      cfg_bits    = 4'(4 + ($urandom % 7));
      cfg_par     = 3'($urandom % 6);
      cfg_addr_en = 1'($urandom % 2);
      nb   = eff_bits(int'(cfg_bits));
      d    = 9'($urandom);
      flip = (cfg_par >= 3'd1 && cfg_par <= 3'd4) && (($urandom % 4) == 0);
      bad  = (($urandom % 4) == 0);
      if (bad) d[0] = 1'b1;
      m  = d & 9'((1 << nb) - 1);
      ad = cfg_addr_en && (nb == 9) && m[8];
      send(d, flip, bad);
      pop_expect("R2 R3 R4 R6 random char", m, flip, bad, ad);
    end

    // R6: directed address marker, raises irq alone
    cfg_bits = 4'd9; cfg_par = 3'd0; cfg_addr_en = 1'b1; cfg_trig = 2'd3;
    send(9'h1A5, 0, 0);
    chk("R10 irq on address marker", irq, 1);
    pop_expect("R6 address marker", 9'h1A5, 0, 0, 1);
    cfg_addr_en = 1'b0;
    send(9'h1A5, 0, 0);
    pop_expect("R6 marker disabled", 9'h1A5, 0, 0, 0);

    // R10: parity error raises irq
    cfg_bits = 4'd8; cfg_par = 3'd1;
    send(9'h033, 1, 0);
    chk("R10 irq on parity error", irq, 1);
    pop_expect("R3 even parity error", 9'h033, 1, 0, 0);

    // R1: short low glitch is rejected
    cfg_par = 3'd0;
    rx_in = 1'b0; repeat (12) @(negedge clk);
    rx_in = 1'b1; repeat (2*BITCLK) @(negedge clk);
    chk("R1 glitch ignored", rd_valid, 0);

    // R10: threshold 1/2 of four
    cfg_deep = 1'b1; cfg_trig = 2'd1;
    send(9'h011, 0, 0);
    chk("R10 irq below threshold", irq, 0);
    send(9'h022, 0, 0);
    chk("R10 irq at threshold", irq, 1);
    pop_expect("R7 order first", 9'h011, 0, 0, 0);
    pop_expect("R7 order second", 9'h022, 0, 0, 0);

    // R7 R8: fill four, overrun on fifth
    cfg_trig = 2'd3;
    for (int i = 0; i < 5; i++) send(9'(8'h40 + i), 0, 0);
    chk("R7 level full", rd_level, 4);
    chk("R8 overrun set", ovr_flag, 1);
    chk("R9 head held", rd_data, 9'h040);
    pop_expect("R8 kept oldest", 9'h040, 0, 0, 0);
    chk("R8 overrun cleared by pop", ovr_flag, 0);
    for (int i = 1; i < 4; i++) pop_expect("R7 drain order", 9'(8'h40 + i), 0, 0, 0);
    chk("R7 empty after drain", rd_valid, 0);

    // R7 R8: single entry queue
    cfg_deep = 1'b0;
    send(9'h05A, 0, 0);
    chk("R10 irq depth one", irq, 1);
    send(9'h0A5, 0, 0);
    chk("R7 depth one level", rd_level, 1);
    chk("R8 overrun depth one", ovr_flag, 1);
    pop_expect("R8 depth one kept first", 9'h05A, 0, 0, 0);
    cfg_deep = 1'b1;

    // R5: break
    cfg_bits = 4'd8; cfg_par = 3'd0;
    rx_in = 1'b0; repeat (14*BITCLK) @(negedge clk);
    rx_in = 1'b1; repeat (2*BITCLK) @(negedge clk);
    chk("R5 break event count", brk_cnt, 1);
    chk("R5 no entry on break", rd_valid, 0);
    send(9'h0C3, 0, 0);
    pop_expect("R5 receive after break", 9'h0C3, 0, 0, 0);

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (190000) @(negedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end
endmodule